// File: doc/BRIEF.md
# Hardware Error Status and Severity Logger

This block collects single-cycle error pulses from the rest of a link controller and keeps a software-visible record of them. Errors fall into two groups: twelve uncorrectable sources and six correctable sources. Each group has a sticky status register and a mask register. The uncorrectable group also has a severity register, which decides whether a recorded event counts as fatal or non-fatal. A four-bit summary register gathers the classes seen so far. A first-error pointer keeps the index of the uncorrectable event that started the current burst of errors.

Software uses a single-cycle register port with word addresses. Read data appears one cycle after the read strobe. Status bits are cleared by writing ones to them. Three one-cycle report outputs tell downstream logic that a new correctable, non-fatal or fatal error has just been recorded.

Top module: `err_logger`

## Requirements
- R1: After reset every status register, the uncorrectable mask, the severity register, the summary register and the pointer read as 0. The correctable mask reads 0x20, so the advisory bit (index 5) starts masked.
- R2: An event whose mask bit is clear sets its status bit at the clock edge where it is sampled. Uncorrectable indices run from 0 (link protocol) to 11 (access control violation). Unsupported request is index 10 and completion timeout is index 4. Correctable indices run from 0 (receiver error) to 5 (advisory).
- R3: An event whose mask bit is set leaves its status bit unchanged and raises no report output.
- R4: Writing to a status register or to the summary register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When an event and a write-1-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R6: cor_report is high for exactly the one cycle after a cycle in which at least one unmasked correctable event was sampled.
- R7: An unmasked uncorrectable event with its severity bit set raises fatal_report for one cycle. With the severity bit clear it raises nonfatal_report instead. Both outputs can pulse together.
- R8: Summary register bits: bit 0 is correctable, bit 1 is non-fatal, bit 2 is fatal, and bit 3 is unsupported request (uncorrectable index 10). Each bit is set by the recorded events of its class.
- R9: The pointer loads the lowest index among the unmasked uncorrectable events of a cycle, but only if the uncorrectable status is all zero before that edge. Otherwise it holds its value.
- R10: Register map by word address: 0 summary, 1 uncorrectable status, 2 uncorrectable mask, 3 severity, 4 correctable status, 5 correctable mask, 6 pointer (read-only). Other addresses read 0. Writes to the pointer or to an undefined address change nothing. Read data is registered, and it is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unc_evt | input | 12 | Uncorrectable error pulses, one per source |
| cor_evt | input | 6 | Correctable error pulses, one per source |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| cor_report | output | 1 | One-cycle pulse per cycle with a new correctable record |
| nonfatal_report | output | 1 | One-cycle pulse for a new non-fatal record |
| fatal_report | output | 1 | One-cycle pulse for a new fatal record |

## Verification
Two things can fall in the same cycle: an arriving event and a software write-1-to-clear of the same status bit. Another pair is a fresh uncorrectable event and a pointer capture while older status is still pending. The bench provokes both by driving an event pulse in the cycle that carries the clearing write, and by sending new events while status is set. A behavioural model in the bench predicts the register contents and the report pulses for every clock. The design is compared against that model on each cycle, and read-backs confirm that the bit survived and that the pointer held.

// File: rtl/err_logger_pkg.sv
package err_logger_pkg;
  // word addresses of the register set
  localparam int ADR_SUM     = 0;
  localparam int ADR_UNC_STS = 1;
  localparam int ADR_UNC_MSK = 2;
  localparam int ADR_UNC_SEV = 3;
  localparam int ADR_COR_STS = 4;
  localparam int ADR_COR_MSK = 5;
  localparam int ADR_PTR     = 6;
  // summary register bit positions
  localparam int SUM_W   = 4;
  localparam int SUM_COR = 0;
  localparam int SUM_NF  = 1;
  localparam int SUM_FAT = 2;
  localparam int SUM_UR  = 3;
endpackage

// File: rtl/err_src_group.sv
module err_src_group #(
  parameter int N = 12,
  parameter logic [N-1:0] MASK_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         mask_we,
  input  logic         sts_w1c,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] sts,
  output logic [N-1:0] mask,
  output logic [N-1:0] hit
);
  logic [N-1:0] clr;

  assign hit = evt & ~mask;
  assign clr = sts_w1c ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts  <= '0;
      mask <= MASK_RST;
    end else begin
      sts <= (sts & ~clr) | hit;  // a new event overrides a clear
      if (mask_we) mask <= wdata;
    end
  end

  // R3
  masked_no_record_chk: assert property (@(posedge clk) disable iff (rst)
    (sts & ~$past(sts) & $past(mask)) == '0);
  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((sts & $past(hit)) == $past(hit)));
  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sts_w1c |=> ((sts & $past(wdata & ~hit)) == '0));
endmodule

// File: rtl/err_first_ptr.sv
module err_first_ptr #(
  parameter int N = 12,
  parameter int PTR_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     sts,
  input  logic [N-1:0]     hit,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] lowest;

  always_comb begin
    lowest = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) lowest = PTR_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (sts == '0 && hit != '0) ptr <= lowest;
  end

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sts != '0) |=> $stable(ptr));
  // R9
  ptr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |=> $stable(ptr));
endmodule

// File: rtl/err_logger.sv
module err_logger
  import err_logger_pkg::*;
#(
  parameter int UNC_N   = 12,
  parameter int COR_N   = 6,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int UR_IDX  = 10,
  parameter int ADV_IDX = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [UNC_N-1:0]  unc_evt,
  input  logic [COR_N-1:0]  cor_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cor_report,
  output logic              nonfatal_report,
  output logic              fatal_report
);
  localparam int PTR_W = $clog2(UNC_N);
  localparam logic [COR_N-1:0] COR_MASK_RST = {{(COR_N-1){1'b0}}, 1'b1} << ADV_IDX;

  logic [UNC_N-1:0] unc_sts, unc_mask, unc_hit, unc_sev;
  logic [COR_N-1:0] cor_sts, cor_mask, cor_hit;
  logic [PTR_W-1:0] first_ptr;
  logic [SUM_W-1:0] sum_sts, sum_hit, sum_clr;
  logic [DATA_W-1:0] rd_mux;
  logic wr_sum, wr_usts, wr_umsk, wr_sev, wr_csts, wr_cmsk;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:UNC_N];

  assign wr_sum  = reg_wr && (reg_addr == ADDR_W'(ADR_SUM));
  assign wr_usts = reg_wr && (reg_addr == ADDR_W'(ADR_UNC_STS));
  assign wr_umsk = reg_wr && (reg_addr == ADDR_W'(ADR_UNC_MSK));
  assign wr_sev  = reg_wr && (reg_addr == ADDR_W'(ADR_UNC_SEV));
  assign wr_csts = reg_wr && (reg_addr == ADDR_W'(ADR_COR_STS));
  assign wr_cmsk = reg_wr && (reg_addr == ADDR_W'(ADR_COR_MSK));

  err_src_group #(.N(UNC_N), .MASK_RST('0)) u_unc (
    .clk(clk), .rst(rst), .evt(unc_evt), .mask_we(wr_umsk), .sts_w1c(wr_usts),
    .wdata(reg_wdata[UNC_N-1:0]), .sts(unc_sts), .mask(unc_mask), .hit(unc_hit)
  );

  err_src_group #(.N(COR_N), .MASK_RST(COR_MASK_RST)) u_cor (
    .clk(clk), .rst(rst), .evt(cor_evt), .mask_we(wr_cmsk), .sts_w1c(wr_csts),
    .wdata(reg_wdata[COR_N-1:0]), .sts(cor_sts), .mask(cor_mask), .hit(cor_hit)
  );

  err_first_ptr #(.N(UNC_N), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .sts(unc_sts), .hit(unc_hit), .ptr(first_ptr)
  );

  // severity register
  always_ff @(posedge clk) begin
    if (rst) unc_sev <= '0;
    else if (wr_sev) unc_sev <= reg_wdata[UNC_N-1:0];
  end

  // class summary and report pulses
  always_comb begin
    sum_hit          = '0;
    sum_hit[SUM_COR] = |cor_hit;
    sum_hit[SUM_NF]  = |(unc_hit & ~unc_sev);
    sum_hit[SUM_FAT] = |(unc_hit & unc_sev);
    sum_hit[SUM_UR]  = unc_hit[UR_IDX];
  end
  assign sum_clr = wr_sum ? reg_wdata[SUM_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_sts         <= '0;
      cor_report      <= 1'b0;
      nonfatal_report <= 1'b0;
      fatal_report    <= 1'b0;
    end else begin
      sum_sts         <= (sum_sts & ~sum_clr) | sum_hit;
      cor_report      <= sum_hit[SUM_COR];
      nonfatal_report <= sum_hit[SUM_NF];
      fatal_report    <= sum_hit[SUM_FAT];
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(ADR_SUM):     rd_mux = DATA_W'(sum_sts);
      ADDR_W'(ADR_UNC_STS): rd_mux = DATA_W'(unc_sts);
      ADDR_W'(ADR_UNC_MSK): rd_mux = DATA_W'(unc_mask);
      ADDR_W'(ADR_UNC_SEV): rd_mux = DATA_W'(unc_sev);
      ADDR_W'(ADR_COR_STS): rd_mux = DATA_W'(cor_sts);
      ADDR_W'(ADR_COR_MSK): rd_mux = DATA_W'(cor_mask);
      ADDR_W'(ADR_PTR):     rd_mux = DATA_W'(first_ptr);
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_rd ? rd_mux : '0;
  end

  // R8
  summary_cor_chk: assert property (@(posedge clk) disable iff (rst)
    cor_report |-> sum_sts[SUM_COR]);
  // R7
  summary_fatal_chk: assert property (@(posedge clk) disable iff (rst)
    fatal_report |-> sum_sts[SUM_FAT]);
endmodule

// File: tb/err_logger_bench.sv
module err_logger_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] unc_evt = '0;
  logic [5:0]  cor_evt = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cor_report, nonfatal_report, fatal_report;

  err_logger u_err_logger (
    .clk(clk), .rst(rst), .unc_evt(unc_evt), .cor_evt(cor_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cor_report(cor_report),
    .nonfatal_report(nonfatal_report), .fatal_report(fatal_report)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference model
  logic [11:0] m_us, m_um, m_sev;
  logic [5:0]  m_cs, m_cm;
  logic [3:0]  m_sum;
  int          m_ptr;
  logic [31:0] e_rdata;
  logic        e_cor, e_nf, e_fat;

  always @(posedge clk) begin
    if (rst) begin
      m_us = 0; m_um = 0; m_sev = 0; m_cs = 0; m_cm = 6'h20; m_sum = 0; m_ptr = 0;
      e_rdata = 0; e_cor = 0; e_nf = 0; e_fat = 0;
    end else begin
      logic [11:0] hu;
      logic [5:0]  hc;
      e_rdata = 0;
      if (reg_rd) begin
        case (reg_addr)
          0: e_rdata = {28'd0, m_sum};
          1: e_rdata = {20'd0, m_us};
          2: e_rdata = {20'd0, m_um};
          3: e_rdata = {20'd0, m_sev};
          4: e_rdata = {26'd0, m_cs};
          5: e_rdata = {26'd0, m_cm};
          6: e_rdata = m_ptr;
          default: e_rdata = 0;
        endcase
      end
      hu = unc_evt & ~m_um;
      hc = cor_evt & ~m_cm;
      e_cor = (hc != 0);
      e_nf  = ((hu & ~m_sev) != 0);
      e_fat = ((hu & m_sev) != 0);
      if (m_us == 0) begin
        for (int i = 0; i < 12; i++) begin
          if (hu[i]) begin m_ptr = i; break; end
        end
      end
      if (reg_wr) begin
        case (reg_addr)
          0: m_sum = m_sum & ~reg_wdata[3:0];
          1: m_us  = m_us & ~reg_wdata[11:0];
          2: m_um  = reg_wdata[11:0];
          3: m_sev = reg_wdata[11:0];
          4: m_cs  = m_cs & ~reg_wdata[5:0];
          5: m_cm  = reg_wdata[5:0];
          default: ;
        endcase
      end
      m_us  = m_us | hu;
      m_cs  = m_cs | hc;
      m_sum = m_sum | {hu[10], e_fat, e_nf, e_cor};
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R6", "cor_report", {31'd0, cor_report}, {31'd0, e_cor});
      check("R7", "nonfatal_report", {31'd0, nonfatal_report}, {31'd0, e_nf});
      check("R7", "fatal_report", {31'd0, fatal_report}, {31'd0, e_fat});
      check(cur_req, "rdata", reg_rdata, e_rdata);
    end
  end

  task automatic cyc(logic [11:0] ue, logic [5:0] ce, logic wr, logic rd,
                     logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    #1;
    unc_evt = ue; cor_evt = ce; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(string req, logic [3:0] a);
    cyc(0, 0, 0, 1, a, 0);
    cur_req = req;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    cyc(0, 0, 1, 0, a, d);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;
    // R1 / R10: reset values and the whole map, including undefined addresses
    for (int a = 0; a < 16; a++) rd(a < 7 ? "R1" : "R10", 4'(a));
    idle();
    // R2 / R7: completion timeout, non-fatal
    cur_req = "R2";
    cyc(12'h010, 0, 0, 0, 0, 0);
    rd("R2", 1); rd("R9", 6); rd("R8", 0);
    // R9: new events while status pending leave pointer at 4
    cyc(12'h204, 0, 0, 0, 0, 0);
    rd("R9", 6); rd("R2", 1);
    // R4: clear with zeros leaves, clear with ones empties
    wr(1, 0); rd("R4", 1);
    wr(1, 32'hFFF); rd("R4", 1);
    wr(0, 32'h1); rd("R4", 0);
    // R7 / R9: fatal and non-fatal together, lowest index wins
    wr(3, 32'h080);
    cyc(12'h088, 0, 0, 0, 0, 0);
    rd("R9", 6); rd("R7", 0); rd("R7", 3);
    // R3: masked uncorrectable and the reset-masked advisory source
    wr(1, 32'hFFF); wr(0, 32'hF);
    wr(2, 32'h001);
    cyc(12'h001, 6'h20, 0, 0, 0, 0);
    rd("R3", 1); rd("R3", 4); rd("R3", 0); rd("R3", 6);
    // R6: correctable event
    cyc(0, 6'h02, 0, 0, 0, 0);
    rd("R6", 4); rd("R8", 0);
    // R5: event and clear of the same bit in one cycle
    cyc(0, 6'h02, 1, 0, 4, 32'h02);
    rd("R5", 4);
    cyc(12'h100, 0, 1, 0, 1, 32'h100);
    rd("R5", 1);
    // R8: unsupported request sets bit 3, then summary clears
    wr(1, 32'hFFF); wr(0, 32'hF);
    cyc(12'h400, 0, 0, 0, 0, 0);
    rd("R8", 0);
    wr(0, 32'hF); rd("R8", 0);
    // R10: pointer and undefined addresses ignore writes
    wr(6, 32'h5); wr(9, 32'hFFFF); rd("R10", 6); rd("R10", 9); rd("R10", 1);
    // R1-like restore: unmask and check mask write path
    wr(5, 0); cyc(0, 6'h20, 0, 0, 0, 0); rd("R2", 4);
    idle(); idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule